// File: doc/BRIEF.md
# Ranked interrupt vector selector

This block keeps a pending flag and an enable bit for each of sixteen ranked interrupt sources. When a vector-select operation is strobed, it picks the highest-ranked source that is active at that moment. The winner is not necessarily the source that first caused interrupt entry: a higher-ranked source that arrives between entry and the select operation takes precedence. The block then returns the two-byte vector-pair address of the winner and a one-hot acknowledge.

Rank 1 is a software trap. It is latched from its own request line and cannot be masked. Ranks 3 to 7 and 11 to 13 are maskable sources. Ranks 2, 8, 9, 10, 14 and 15 are reserved and stay idle. Rank 16 is the default entry and is returned when nothing is active.

Sources that lose arbitration keep their pending flags. They can therefore interrupt again as soon as the current service returns.

Top module: `vec_select`

## Requirements
- R1: After reset, all pending flags, the trap latch and all enable bits are 0, `vld` and `ack` are 0, and `vec_addr` is 16'h00E0.
- R2: A maskable source is active only when both its enable bit and its pending flag are 1. A pending source that is disabled does not win, but it stays pending and wins a later select once it is enabled.
- R3: On a select strobe, the active source with the smallest rank number wins. Bit i of `set_pulse`, `en_wdata` and `ack` belongs to rank i+1.
- R4: For a winner of rank r, `vec_addr` is {4'h0, page, 8'hFE - 2*(r-1)}. The page is the value sampled with the strobe.
- R5: If no source is active at the strobe, `ack` is all zero and `vec_addr` is {4'h0, page, 8'hE0}, which is the rank-16 default.
- R6: Set pulses and enables on reserved ranks 2, 8, 9, 10, 14 and 15, and on rank 16, have no effect. These ranks never win arbitration.
- R7: A select clears only the winner's pending flag. Losing sources stay pending.
- R8: If a set pulse for the winning source arrives in the same cycle as its select, the set takes priority and the flag stays pending.
- R9: A `trap_req` pulse is latched as a rank-1 request that wins regardless of any enable bit. The latch is cleared when the trap is selected.
- R10: `vld` pulses for one cycle, one clock after a select strobe. `ack` carries the winner's one-hot bit only in that cycle. `vec_addr` is updated at the same edge and then held until the next strobe.
- R11: When `en_we` is 1, all sixteen enable bits are loaded from `en_wdata` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pulse | input | 16 | Per-rank pending set pulses, bit i is rank i+1 |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 16 | Enable register write data |
| trap_req | input | 1 | Software trap request pulse |
| page | input | 4 | Vector table page digit |
| sel | input | 1 | Vector-select strobe |
| vld | output | 1 | Result valid, one cycle after `sel` |
| ack | output | 16 | One-hot acknowledge of the winning rank |
| vec_addr | output | 16 | Low address of the winner's vector pair |

## Verification
A set pulse, trap request or enable write takes effect at the first rising edge that samples it. The select result appears on `vld`, `ack` and `vec_addr` at the rising edge that samples `sel`. The bench drives every input on the falling edge and reads the results on the next falling edge, which is exactly one register stage later. Pending state is not read directly. Instead, it is observed through later select operations, which shows whether flags were kept, cleared or re-set.

// File: rtl/vec_select.sv
module vec_select (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] set_pulse,
  input  logic        en_we,
  input  logic [15:0] en_wdata,
  input  logic        trap_req,
  input  logic [3:0]  page,
  input  logic        sel,
  output logic        vld,
  output logic [15:0] ack,
  output logic [15:0] vec_addr
);
  localparam logic [15:0] USABLE = 16'h1C7C;

  logic [15:0] en_q, pend_q, act, win_oh, clr;
  logic [3:0]  win_idx;
  logic        trap_q;

  assign act = (pend_q & en_q & USABLE) | {15'b0, trap_q};

  always_comb begin
    win_idx = 4'd15;
    for (int i = 15; i >= 0; i--)
      if (act[i]) win_idx = 4'(i);
  end

  assign win_oh = (|act) ? (16'd1 << win_idx) : 16'd0;
  assign clr    = sel ? win_oh : 16'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      pend_q   <= '0;
      trap_q   <= 1'b0;
      vld      <= 1'b0;
      ack      <= '0;
      vec_addr <= 16'h00E0;
    end else begin
      if (en_we) en_q <= en_wdata;
      pend_q <= ((pend_q & ~clr) | set_pulse) & USABLE;
      trap_q <= (trap_q & ~clr[0]) | trap_req;
      vld    <= sel;
      ack    <= clr;
      if (sel) vec_addr <= {4'h0, page, 8'hFE - {3'b0, win_idx, 1'b0}};
    end
  end
endmodule

module vec_select_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic [3:0]  page,
  input logic        vld,
  input logic [15:0] ack,
  input logic [15:0] vec_addr,
  input logic [15:0] pend
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack)); // R10
  AST_VLD_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n) sel |=> vld); // R10
  AST_NO_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !vld |-> ack == 16'd0); // R10
  AST_RESERVED_NEVER: assert property (@(posedge clk) disable iff (!rst_n) (ack & 16'hE382) == 16'd0); // R6
  AST_ACK_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n) (ack & ~$past(pend)) == 16'd0); // R7
  AST_ADDR_PAGE: assert property (@(posedge clk) disable iff (!rst_n) vld |-> vec_addr[15:8] == {4'h0, $past(page)}); // R4
  AST_DEFAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n) (vld && ack == 16'd0) |-> vec_addr[7:0] == 8'hE0); // R5
endmodule

bind vec_select vec_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .page(page), .vld(vld),
  .ack(ack), .vec_addr(vec_addr), .pend({pend_q[15:1], trap_q})
);

// File: tb/vec_select_tb.sv
module vec_select_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] set_pulse = '0, en_wdata = '0;
  logic        en_we = 1'b0, trap_req = 1'b0, sel = 1'b0;
  logic [3:0]  page = 4'h0;
  logic        vld;
  logic [15:0] ack, vec_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  vec_select u_dut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] m);
    @(negedge clk) set_pulse = m;
    @(negedge clk) set_pulse = '0;
  endtask

  task automatic wr_en(input logic [15:0] v);
    @(negedge clk) begin en_we = 1'b1; en_wdata = v; end
    @(negedge clk) en_we = 1'b0;
  endtask

  task automatic do_sel(input int idx, input string req);
    logic [15:0] ea, ek;
    @(negedge clk) sel = 1'b1;
    @(negedge clk) sel = 1'b0;
    ek = (idx < 0) ? 16'd0 : (16'd1 << idx);
    ea = {4'h0, page, (idx < 0) ? 8'hE0 : 8'(8'hFE - 2 * idx)};
    chk(vld === 1'b1, req, {31'd0, vld}, 32'd1);
    chk(ack === ek, req, {16'd0, ack}, {16'd0, ek});
    chk(vec_addr === ea, req, {16'd0, vec_addr}, {16'd0, ea});
  endtask

  task automatic t_reset;
    chk(vld === 1'b0 && ack === 16'd0, "R1", {15'd0, vld, ack}, 32'd0);
    chk(vec_addr === 16'h00E0, "R1", {16'd0, vec_addr}, 32'h00E0);
    do_sel(-1, "R5 empty select");
  endtask

  task automatic t_mask;
    pulse(16'h0008);
    do_sel(-1, "R2 disabled source");
    wr_en(16'h0008);
    do_sel(3, "R2 R11 enabled later");
    do_sel(-1, "R7 cleared after win");
  endtask

  task automatic t_priority;
    page = 4'h5;
    wr_en(16'h1014);
    pulse(16'h1010);
    do_sel(4, "R3 higher rank wins");
    pulse(16'h0004);
    do_sel(2, "R3 late higher rank wins");
    do_sel(12, "R7 loser stayed pending");
    do_sel(-1, "R5 default with page");
  endtask

  task automatic t_reserved;
    wr_en(16'hFFFF);
    pulse(16'hE382);
    do_sel(-1, "R6 reserved ignored");
  endtask

  task automatic t_trap;
    page = 4'hA;
    wr_en(16'h0010);
    pulse(16'h0010);
    @(negedge clk) trap_req = 1'b1;
    @(negedge clk) trap_req = 1'b0;
    do_sel(0, "R9 trap wins unmasked");
    do_sel(4, "R9 trap cleared");
  endtask

  task automatic t_setwins;
    wr_en(16'h0014);
    pulse(16'h0014);
    @(negedge clk) begin sel = 1'b1; set_pulse = 16'h0004; end
    @(negedge clk) begin sel = 1'b0; set_pulse = '0; end
    chk(ack === 16'h0004, "R8 first win", {16'd0, ack}, 32'h0004);
    do_sel(2, "R8 set kept pending");
    do_sel(4, "R8 loser");
  endtask

  task automatic t_hold;
    page = 4'h3;
    wr_en(16'h0040);
    pulse(16'h0040);
    do_sel(6, "R10 result");
    page = 4'h9;
    repeat (3) @(negedge clk);
    chk(vld === 1'b0 && ack === 16'd0, "R10 pulse only", {15'd0, vld, ack}, 32'd0);
    chk(vec_addr === 16'h03F2, "R10 addr held", {16'd0, vec_addr}, 32'h03F2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mask;
    t_priority;
    t_reserved;
    t_trap;
    t_setwins;
    t_hold;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule